// File: doc/BRIEF.md
# Processor low-power state controller

This block decides when the core clock of a simple processor may be gated off. It tracks the processor through five power states: running, halted with the clock stopped, stop-grant, a snoop state that wakes the clock for a cache snoop, and a flush state that wakes the clock for a cache flush. A halt request or a stop-clock request takes the core into a clock-off state and issues a one-cycle request for the matching bus cycle. External snoops and cache flushes then wake the clock only for as long as the cache work takes.

The two wake-up states are transient. Each remembers the state it interrupted and returns there when its work is done, and it issues no new halt or stop-grant bus cycle on that return. A flush is accepted only from the halted state. In write-back mode it runs three steps in order: dirty-line write-back, invalidation, and a configurable number of flush-acknowledge bus cycles. In write-through mode it runs only the invalidation. While the clock is stopped, hold, address-hold and back-off requests float the bus and leave the power state alone.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the block is in the running state. In that state core_clk_en_o is 1 and every request, start and float output is 0.
- R2: In the running state with stop_clk_ni high, halt_req_i high at a clock edge gives halt_cyc_o high for exactly the next cycle. core_clk_en_o goes to 0 in that same cycle, and the block is then halted.
- R3: When the block is halted or running and there is no snoop and no flush to serve, stop_clk_ni low at an edge gives stop_grant_cyc_o high for exactly the next cycle. The block enters stop-grant with core_clk_en_o 0. A halt_req_i in that same edge from the running state is discarded.
- R4: In stop-grant, stop_clk_ni high at an edge returns the block to the state that stop-grant was entered from. From the halted state the clock stays 0; from the running state the clock goes back to 1. The return pulses neither halt_cyc_o nor stop_grant_cyc_o.
- R5: While halted or in stop-grant, bus_float_o equals hold_i OR ahold_i OR NOT backoff_ni in the same cycle. In all other states it is 0. None of these inputs changes the power state or the clock enable.
- R6: A snoop_i at an edge while halted or in stop-grant gives core_clk_en_o 1 and snoop_start_o high for exactly the next cycle. The clock stays on until snoop_done_i is seen. The edge after that returns the block to the interrupted state with the clock off and no bus cycle request.
- R7: flush_ni low at an edge while halted starts a flush with core_clk_en_o 1. In write-back mode (wb_mode_i 1, sampled at that edge) the flush pulses wb_start_o and waits for wb_done_i. It then pulses inv_start_o and waits for inv_done_i. It then issues NUM_ACK (default 2) flush_ack_cyc_o pulses, each one after ack_done_i for the previous pulse. Each pulse is one cycle long and comes in the cycle after its trigger. After the last ack_done_i the block returns to halted with the clock off and no bus cycle request.
- R8: In write-through mode (wb_mode_i 0) the flush pulses only inv_start_o. It returns to halted at the edge after inv_done_i, with no write-back step and no flush-acknowledge pulse.
- R9: flush_ni low while in stop-grant is ignored. There is no start pulse and the clock stays off, and it is not remembered: after the return to halted the block stays halted with the clock off.
- R10: While halted, a snoop takes priority over a flush, and a flush takes priority over stop-clock. A flush that arrives in the same edge as a snoop is held. It is started one cycle after the return from the snoop. Stop-clock held low is served only after the snoop or flush work is done.
- R11: A done input that arrives outside the step it belongs to has no effect on the sequence, on the outputs or on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_req_i | input | 1 | Halt request strobe from the core |
| stop_clk_ni | input | 1 | Stop-clock request level, active low |
| flush_ni | input | 1 | Cache flush request strobe, active low |
| snoop_i | input | 1 | External snoop strobe |
| hold_i | input | 1 | Bus hold request |
| ahold_i | input | 1 | Address hold request |
| backoff_ni | input | 1 | Bus back-off request, active low |
| snoop_done_i | input | 1 | Snoop and its write-back finished |
| wb_done_i | input | 1 | Dirty-line write-back finished |
| inv_done_i | input | 1 | Cache invalidation finished |
| ack_done_i | input | 1 | Current flush-acknowledge bus cycle finished |
| wb_mode_i | input | 1 | 1 = write-back cache, 0 = write-through |
| core_clk_en_o | output | 1 | Core clock gate enable |
| halt_cyc_o | output | 1 | One-cycle halt bus cycle request |
| stop_grant_cyc_o | output | 1 | One-cycle stop-grant bus cycle request |
| flush_ack_cyc_o | output | 1 | One-cycle flush-acknowledge bus cycle request |
| snoop_start_o | output | 1 | One-cycle snoop work start |
| wb_start_o | output | 1 | One-cycle dirty-line write-back start |
| inv_start_o | output | 1 | One-cycle invalidation start |
| bus_float_o | output | 1 | Bus outputs must float |

## Verification
Snoops are applied both from the halted state and from stop-grant. Only the right return target tells the two return paths apart. Flushes are run in both cache modes, with stray done pulses placed inside the wrong step, so that a sequencer which skips a step or counts the acknowledges wrongly shows up. Snoop, flush and stop-clock are applied in the same cycle, and a flush is applied during stop-grant, to pin down the priority, the held flush and the dropped flush. Stop-grant is also entered from the running state with a halt request in the same cycle, which checks that stop-grant returns to the right state and that the halt request is discarded.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    PS_RUN, PS_HALT, PS_GRANT, PS_SNOOP, PS_FLUSH
  } pwr_state_e;

  typedef enum logic [1:0] {
    FS_IDLE, FS_WB, FS_INV, FS_ACK
  } flush_step_e;

  function automatic logic clk_off(pwr_state_e s);
    return (s == PS_HALT) || (s == PS_GRANT);
  endfunction
endpackage

// File: rtl/pwr_next_state.sv
module pwr_next_state
  import pwr_pkg::*;
(
  input  pwr_state_e state_i,
  input  logic       grant_ret_halt_i,
  input  logic       snoop_ret_grant_i,
  input  logic       flush_pend_i,
  input  logic       halt_req_i,
  input  logic       stop_req_i,
  input  logic       flush_req_i,
  input  logic       snoop_req_i,
  input  logic       snoop_done_i,
  input  logic       flush_done_i,
  output pwr_state_e state_d_o,
  output logic       ev_halt_o,
  output logic       ev_grant_o,
  output logic       ev_snoop_o,
  output logic       ev_flush_o,
  output logic       set_pend_o
);
  always_comb begin
    state_d_o  = state_i;
    ev_halt_o  = 1'b0;
    ev_grant_o = 1'b0;
    ev_snoop_o = 1'b0;
    ev_flush_o = 1'b0;
    set_pend_o = 1'b0;
    unique case (state_i)
      PS_RUN: begin
        if (stop_req_i) begin
          state_d_o  = PS_GRANT;
          ev_grant_o = 1'b1;
        end else if (halt_req_i) begin
          state_d_o = PS_HALT;
          ev_halt_o = 1'b1;
        end
      end
      PS_HALT: begin
        if (snoop_req_i) begin
          state_d_o  = PS_SNOOP;
          ev_snoop_o = 1'b1;
          set_pend_o = flush_req_i;
        end else if (flush_req_i || flush_pend_i) begin
          state_d_o  = PS_FLUSH;
          ev_flush_o = 1'b1;
        end else if (stop_req_i) begin
          state_d_o  = PS_GRANT;
          ev_grant_o = 1'b1;
        end
      end
      PS_GRANT: begin
        if (snoop_req_i) begin
          state_d_o  = PS_SNOOP;
          ev_snoop_o = 1'b1;
        end else if (!stop_req_i) begin
          state_d_o = grant_ret_halt_i ? PS_HALT : PS_RUN;
        end
      end
      PS_SNOOP: begin
        if (snoop_done_i) state_d_o = snoop_ret_grant_i ? PS_GRANT : PS_HALT;
      end
      PS_FLUSH: begin
        if (flush_done_i) state_d_o = PS_HALT;
      end
      default: state_d_o = PS_RUN;
    endcase
  end
endmodule

// File: rtl/pwr_flush_seq.sv
module pwr_flush_seq
  import pwr_pkg::*;
#(
  parameter int NUM_ACK = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic wb_mode_i,
  input  logic wb_done_i,
  input  logic inv_done_i,
  input  logic ack_done_i,
  output logic wb_start_o,
  output logic inv_start_o,
  output logic ack_cyc_o,
  output logic done_o
);
  localparam int ACW = (NUM_ACK > 1) ? $clog2(NUM_ACK) : 1;
  localparam logic [ACW-1:0] LAST_ACK = ACW'(NUM_ACK - 1);

  flush_step_e    step_q;
  logic [ACW-1:0] ack_cnt_q;
  logic           wbm_q;

  assign done_o = ((step_q == FS_INV) && inv_done_i && !wbm_q) ||
                  ((step_q == FS_ACK) && ack_done_i && (ack_cnt_q == LAST_ACK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q      <= FS_IDLE;
      ack_cnt_q   <= '0;
      wbm_q       <= 1'b0;
      wb_start_o  <= 1'b0;
      inv_start_o <= 1'b0;
      ack_cyc_o   <= 1'b0;
    end else begin
      wb_start_o  <= 1'b0;
      inv_start_o <= 1'b0;
      ack_cyc_o   <= 1'b0;
      if (start_i) begin
        wbm_q <= wb_mode_i;
        if (wb_mode_i) begin
          step_q     <= FS_WB;
          wb_start_o <= 1'b1;
        end else begin
          step_q      <= FS_INV;
          inv_start_o <= 1'b1;
        end
      end else begin
        unique case (step_q)
          FS_WB: if (wb_done_i) begin
            step_q      <= FS_INV;
            inv_start_o <= 1'b1;
          end
          FS_INV: if (inv_done_i) begin
            if (wbm_q) begin
              step_q    <= FS_ACK;
              ack_cnt_q <= '0;
              ack_cyc_o <= 1'b1;
            end else begin
              step_q <= FS_IDLE;
            end
          end
          FS_ACK: if (ack_done_i) begin
            if (ack_cnt_q == LAST_ACK) begin
              step_q <= FS_IDLE;
            end else begin
              ack_cnt_q <= ack_cnt_q + 1'b1;
              ack_cyc_o <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwr_bus_float.sv
module pwr_bus_float
  import pwr_pkg::*;
(
  input  pwr_state_e state_i,
  input  logic       hold_i,
  input  logic       ahold_i,
  input  logic       backoff_ni,
  output logic       float_o
);
  assign float_o = clk_off(state_i) && (hold_i || ahold_i || !backoff_ni);
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int NUM_ACK = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_req_i,
  input  logic stop_clk_ni,
  input  logic flush_ni,
  input  logic snoop_i,
  input  logic hold_i,
  input  logic ahold_i,
  input  logic backoff_ni,
  input  logic snoop_done_i,
  input  logic wb_done_i,
  input  logic inv_done_i,
  input  logic ack_done_i,
  input  logic wb_mode_i,
  output logic core_clk_en_o,
  output logic halt_cyc_o,
  output logic stop_grant_cyc_o,
  output logic flush_ack_cyc_o,
  output logic snoop_start_o,
  output logic wb_start_o,
  output logic inv_start_o,
  output logic bus_float_o
);
  pwr_state_e state_q, state_d;
  logic grant_ret_halt_q, snoop_ret_grant_q, flush_pend_q;
  logic ev_halt, ev_grant, ev_snoop, ev_flush, set_pend, flush_done;

  pwr_next_state u_next (
    .state_i          (state_q),
    .grant_ret_halt_i (grant_ret_halt_q),
    .snoop_ret_grant_i(snoop_ret_grant_q),
    .flush_pend_i     (flush_pend_q),
    .halt_req_i       (halt_req_i),
    .stop_req_i       (!stop_clk_ni),
    .flush_req_i      (!flush_ni),
    .snoop_req_i      (snoop_i),
    .snoop_done_i     (snoop_done_i),
    .flush_done_i     (flush_done),
    .state_d_o        (state_d),
    .ev_halt_o        (ev_halt),
    .ev_grant_o       (ev_grant),
    .ev_snoop_o       (ev_snoop),
    .ev_flush_o       (ev_flush),
    .set_pend_o       (set_pend)
  );

  pwr_flush_seq #(.NUM_ACK(NUM_ACK)) u_flush (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (ev_flush),
    .wb_mode_i  (wb_mode_i),
    .wb_done_i  (wb_done_i),
    .inv_done_i (inv_done_i),
    .ack_done_i (ack_done_i),
    .wb_start_o (wb_start_o),
    .inv_start_o(inv_start_o),
    .ack_cyc_o  (flush_ack_cyc_o),
    .done_o     (flush_done)
  );

  pwr_bus_float u_float (
    .state_i   (state_q),
    .hold_i    (hold_i),
    .ahold_i   (ahold_i),
    .backoff_ni(backoff_ni),
    .float_o   (bus_float_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q           <= PS_RUN;
      grant_ret_halt_q  <= 1'b0;
      snoop_ret_grant_q <= 1'b0;
      flush_pend_q      <= 1'b0;
      halt_cyc_o        <= 1'b0;
      stop_grant_cyc_o  <= 1'b0;
      snoop_start_o     <= 1'b0;
    end else begin
      state_q          <= state_d;
      halt_cyc_o       <= ev_halt;
      stop_grant_cyc_o <= ev_grant;
      snoop_start_o    <= ev_snoop;
      if (ev_grant) grant_ret_halt_q <= (state_q == PS_HALT);
      if (ev_snoop) snoop_ret_grant_q <= (state_q == PS_GRANT);
      if (ev_flush) flush_pend_q <= 1'b0;
      else if (set_pend) flush_pend_q <= 1'b1;
    end
  end

  assign core_clk_en_o = !clk_off(state_q);
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk
  import pwr_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input pwr_state_e state_i,
  input logic       snoop_done_i,
  input logic       core_clk_en_o,
  input logic       halt_cyc_o,
  input logic       stop_grant_cyc_o,
  input logic       flush_ack_cyc_o,
  input logic       snoop_start_o,
  input logic       wb_start_o,
  input logic       inv_start_o,
  input logic       bus_float_o
);
  a_r2_halt_clk_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_cyc_o |-> !core_clk_en_o);
  a_r3_grant_clk_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_grant_cyc_o |-> !core_clk_en_o);
  a_r6_snoop_clk_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_start_o |-> core_clk_en_o);
  a_r7_flush_clk_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_start_o || inv_start_o || flush_ack_cyc_o) |-> core_clk_en_o);
  a_r5_float_clk_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_float_o |-> !core_clk_en_o);
  a_r6_quiet_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == PS_SNOOP && snoop_done_i) |=>
      (!halt_cyc_o && !stop_grant_cyc_o && !core_clk_en_o));
  a_r4_no_halt_on_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_i) == PS_GRANT && state_i == PS_HALT) |-> !halt_cyc_o);
  a_r9_flush_only_from_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == PS_FLUSH && $past(state_i) != PS_FLUSH) |-> $past(state_i) == PS_HALT);
  a_r7_single_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({halt_cyc_o, stop_grant_cyc_o, flush_ack_cyc_o,
              snoop_start_o, wb_start_o, inv_start_o}));
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .state_i         (state_q),
  .snoop_done_i    (snoop_done_i),
  .core_clk_en_o   (core_clk_en_o),
  .halt_cyc_o      (halt_cyc_o),
  .stop_grant_cyc_o(stop_grant_cyc_o),
  .flush_ack_cyc_o (flush_ack_cyc_o),
  .snoop_start_o   (snoop_start_o),
  .wb_start_o      (wb_start_o),
  .inv_start_o     (inv_start_o),
  .bus_float_o     (bus_float_o)
);

// File: tb/pwr_state_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb;
  localparam int NACK = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, stop_n = 1, flush_n = 1, snoop = 0;
  logic hold = 0, ahold = 0, boff_n = 1;
  logic snoop_done = 0, wb_done = 0, inv_done = 0, ack_done = 0, wb_mode = 1;
  logic clk_en, halt_cyc, sg_cyc, fack_cyc, snoop_st, wb_st, inv_st, flt;

  always #2 clk = ~clk;

  pwr_state_ctrl #(.NUM_ACK(NACK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .halt_req_i(halt_req), .stop_clk_ni(stop_n),
    .flush_ni(flush_n), .snoop_i(snoop), .hold_i(hold), .ahold_i(ahold),
    .backoff_ni(boff_n), .snoop_done_i(snoop_done), .wb_done_i(wb_done),
    .inv_done_i(inv_done), .ack_done_i(ack_done), .wb_mode_i(wb_mode),
    .core_clk_en_o(clk_en), .halt_cyc_o(halt_cyc), .stop_grant_cyc_o(sg_cyc),
    .flush_ack_cyc_o(fack_cyc), .snoop_start_o(snoop_st), .wb_start_o(wb_st),
    .inv_start_o(inv_st), .bus_float_o(flt)
  );

  // reference model: 0 run, 1 halted, 2 stop-grant, 3 snoop, 4 flush
  int m_st, m_sg_from, m_sn_from, m_phase, m_acks;
  bit m_pend, m_wbm;
  bit e_halt, e_sg, e_fack, e_snp, e_wb, e_inv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_sg_from = 0; m_sn_from = 1; m_phase = 0; m_acks = 0;
      m_pend = 0; m_wbm = 0;
      {e_halt, e_sg, e_fack, e_snp, e_wb, e_inv} = '0;
    end else begin
      {e_halt, e_sg, e_fack, e_snp, e_wb, e_inv} = '0;
      case (m_st)
        0: if (!stop_n) begin m_st = 2; m_sg_from = 0; e_sg = 1; end
           else if (halt_req) begin m_st = 1; e_halt = 1; end
        1: if (snoop) begin
             m_st = 3; m_sn_from = 1; e_snp = 1;
             if (!flush_n) m_pend = 1;
           end else if (m_pend || !flush_n) begin
             m_st = 4; m_pend = 0; m_wbm = wb_mode;
             if (wb_mode) begin m_phase = 0; e_wb = 1; end
             else begin m_phase = 1; e_inv = 1; end
           end else if (!stop_n) begin m_st = 2; m_sg_from = 1; e_sg = 1; end
        2: if (snoop) begin m_st = 3; m_sn_from = 2; e_snp = 1; end
           else if (stop_n) m_st = m_sg_from;
        3: if (snoop_done) m_st = m_sn_from;
        4: begin
          if (m_phase == 0) begin
            if (wb_done) begin m_phase = 1; e_inv = 1; end
          end else if (m_phase == 1) begin
            if (inv_done) begin
              if (m_wbm) begin m_phase = 2; m_acks = 0; e_fack = 1; end
              else m_st = 1;
            end
          end else if (ack_done) begin
            if (m_acks == NACK - 1) m_st = 1;
            else begin m_acks++; e_fack = 1; end
          end
        end
        default: m_st = 0;
      endcase
    end
  end

  int vectors = 0, miscompares = 0;
  string cur_req = "R1";
  bit done_flag = 0;

  task automatic cmp(string nm, logic act, logic exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", cur_req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done_flag) begin
      bit e_clk, e_flt;
      e_clk = !(m_st == 1 || m_st == 2);
      e_flt = (m_st == 1 || m_st == 2) && (hold || ahold || !boff_n);
      vectors++;
      cmp("core_clk_en", clk_en, e_clk);
      cmp("halt_cyc", halt_cyc, e_halt);
      cmp("stop_grant_cyc", sg_cyc, e_sg);
      cmp("flush_ack_cyc", fack_cyc, e_fack);
      cmp("snoop_start", snoop_st, e_snp);
      cmp("wb_start", wb_st, e_wb);
      cmp("inv_start", inv_st, e_inv);
      cmp("bus_float", flt, e_flt);
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    cyc(3);
    rst_n = 1;
    cyc(1);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    cyc(20000);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    #1;
    do_reset();
    cyc(2);

    cur_req = "R2";
    halt_req = 1; cyc(); halt_req = 0; cyc(4);

    cur_req = "R5";
    hold = 1; cyc(2); hold = 0; ahold = 1; cyc(2); ahold = 0;
    boff_n = 0; cyc(2); boff_n = 1; cyc(2);

    cur_req = "R3";
    stop_n = 0; cyc(4);
    cur_req = "R5";
    hold = 1; boff_n = 0; cyc(2); hold = 0; boff_n = 1; cyc();
    cur_req = "R6";
    snoop = 1; cyc(); snoop = 0; cyc(3);
    snoop_done = 1; cyc(); snoop_done = 0; cyc(3);
    cur_req = "R9";
    flush_n = 0; cyc(); flush_n = 1; cyc(3);
    cur_req = "R4";
    stop_n = 1; cyc(5);

    cur_req = "R6";
    snoop = 1; cyc(); snoop = 0; hold = 1; cyc(2); hold = 0;
    snoop_done = 1; cyc(); snoop_done = 0; cyc(3);

    cur_req = "R7";
    wb_mode = 1; flush_n = 0; cyc(); flush_n = 1; wb_mode = 0; cyc(2);
    cur_req = "R11";
    inv_done = 1; cyc(); inv_done = 0; ack_done = 1; cyc(); ack_done = 0;
    cur_req = "R7";
    wb_done = 1; cyc(); wb_done = 0; cyc(2);
    cur_req = "R11";
    ack_done = 1; wb_done = 1; cyc(); ack_done = 0; wb_done = 0;
    cur_req = "R7";
    inv_done = 1; cyc(); inv_done = 0; cyc(2);
    ack_done = 1; cyc(); ack_done = 0; cyc(2);
    ack_done = 1; cyc(); ack_done = 0; cyc(4);

    cur_req = "R8";
    wb_mode = 0; flush_n = 0; cyc(); flush_n = 1; cyc();
    cur_req = "R11";
    wb_done = 1; cyc(); wb_done = 0; ack_done = 1; cyc(); ack_done = 0;
    cur_req = "R8";
    inv_done = 1; cyc(); inv_done = 0; cyc(4);

    cur_req = "R10";
    wb_mode = 1; snoop = 1; flush_n = 0; cyc(); snoop = 0; flush_n = 1; cyc(2);
    snoop_done = 1; cyc(); snoop_done = 0; cyc(3);
    wb_done = 1; cyc(); wb_done = 0; cyc();
    inv_done = 1; cyc(); inv_done = 0; cyc();
    ack_done = 1; cyc(); ack_done = 0; cyc();
    ack_done = 1; cyc(); ack_done = 0; cyc(3);
    snoop = 1; stop_n = 0; cyc(); snoop = 0; cyc(2);
    snoop_done = 1; cyc(); snoop_done = 0; cyc(3);
    stop_n = 1; cyc(3);
    wb_mode = 0; flush_n = 0; stop_n = 0; cyc(); flush_n = 1; cyc(2);
    inv_done = 1; cyc(); inv_done = 0; cyc(3);
    stop_n = 1; cyc(3);

    cur_req = "R1";
    do_reset();
    cyc(2);
    cur_req = "R3";
    halt_req = 1; stop_n = 0; cyc(); halt_req = 0; cyc(3);
    cur_req = "R4";
    stop_n = 1; cyc(4);
    cur_req = "R2";
    halt_req = 1; cyc(); halt_req = 0; cyc(3);

    finish_run();
  end
endmodule